// File: doc/BRIEF.md
# Power Register Access Command Engine

This engine sits on the controller side of a command mailbox. It carries out register-access commands that arrive for the power-control register space. The mailbox presents a command word as three fields: a type, a sub-command and a payload size. It also presents a 16-byte outbound buffer. A one-cycle doorbell strobe tells the engine to take them. The engine accepts only commands of the power-control type. It checks the sub-command and size, then unpacks the buffer into a list of 16-bit register addresses and, for writes, the data bytes. It then issues byte accesses on an 8-bit register bus, one access per cycle.

Three operations are supported: reading several registers, writing several registers, and a masked update of one register. Read results are placed into a 16-byte inbound buffer. When the work is finished, the engine raises a one-cycle done pulse with an error flag beside it. A command that is malformed performs no register access and completes at once with the error flag set.

Top module: `pwr_reg_engine`

## Requirements
- R1: After reset the following are low: done, err, regRdEn and regWrEn. All bytes of ibBuf are zero.
- R2: Addresses are unpacked from the outbound buffer. Item i's address is taken with its low byte at buffer byte 2i and its high byte at buffer byte 2i+1. Items are accessed in ascending index order, one bus access per cycle. Read enable and write enable are never high together. The first access happens in the cycle after the doorbell is sampled.
- R3: Read is sub-command 1. Its size must be 2N with N from 1 to 5. The engine samples regRdData in the same cycle as regRdEn. The byte for item n lands in ibBuf byte n (bits 8n+7:8n). All other ibBuf bytes are zero.
- R4: Write is sub-command 0. Its size must be 3N with N from 1 to 5. The data byte for item n is taken from outbound byte 2N+n.
- R5: Masked update is sub-command 2. Its size must be 4. The address is in bytes 0–1, the new value in byte 2 and the mask in byte 3. The engine reads the register in one cycle and writes the same address in the next. The written value is (new & mask) | (old & ~mask).
- R6: Done is a pulse exactly one cycle long. It comes in the cycle after the last access: N+1 cycles after the doorbell for N items, and 3 cycles after it for a masked update. The err output changes only while done is high. It is 0 after a successful command and holds its value until the next done.
- R7: Any of the following is rejected: a sub-command above 2, a size that is not an exact multiple, an item count of 0 or more than 5, or a masked-update size other than 4. A rejected command makes no bus access. It raises done with err=1 one cycle after the doorbell, and it leaves ibBuf all zero.
- R8: A doorbell with a command type other than 0xFF is ignored. No bus access follows and no done pulse follows.
- R9: A doorbell that arrives while a command is in progress is ignored. The running command completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doorbell | input | 1 | One-cycle command start strobe |
| cmdType | input | 8 | Command type; only 0xFF is handled |
| subCmd | input | 4 | 0 write, 1 read, 2 masked update |
| cmdSize | input | 8 | Payload size in bytes |
| obBuf | input | 128 | Outbound buffer, byte k at bits 8k+7:8k |
| regAddr | output | 16 | Register bus address |
| regRdEn | output | 1 | Register read strobe |
| regWrEn | output | 1 | Register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data, valid in the cycle of regRdEn |
| ibBuf | output | 128 | Inbound buffer, byte k at bits 8k+7:8k |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command status, valid with done |

## Verification
The bench checks where the write data sits, because it moves with the item count. A design that used a fixed offset would write address bytes as data in a multi-item write. It checks the masked update both for the order of its read and write and for its merge. A design that reversed either would store the old value, or would store new bits under mask zeros. It checks the size and count limits on both sides of five items and with non-multiple sizes. A design that let one through would touch registers and return err low. Finally, it checks doorbells that carry a foreign type or arrive mid-command. A design that acted on them would add bus accesses or corrupt the running command.

// File: rtl/pwr_reg_pkg.sv
package pwr_reg_pkg;
  localparam int unsigned PWR_BUF_BYTES = 16;
  localparam int unsigned PWR_IDX_W = $clog2(PWR_BUF_BYTES);

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_RMW  = 2'd2,
    OP_NONE = 2'd3
  } pwr_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 latch;    // take outbound buffer, clear inbound buffer
    logic                 capRead;  // store read byte into inbound buffer
    logic                 capOld;   // store old value for masked update
    pwr_op_e              op;
    logic [PWR_IDX_W-1:0] idx;
    logic [PWR_IDX_W-1:0] cnt;
  } pwr_strobe_t;
endpackage

// File: rtl/pwr_reg_ctrl.sv
module pwr_reg_ctrl
  import pwr_reg_pkg::*;
#(
  parameter int unsigned MAX_ITEMS = 5,
  parameter logic [7:0]  CMD_TYPE  = 8'hFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        doorbell,
  input  logic [7:0]  cmdType,
  input  logic [3:0]  subCmd,
  input  logic [7:0]  cmdSize,
  output logic        regRdEn,
  output logic        regWrEn,
  output logic        done,
  output logic        err,
  output pwr_strobe_t strobe
);
  localparam int unsigned IDX_W = PWR_IDX_W;
  localparam logic [7:0] MAX_CNT = 8'(MAX_ITEMS);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_RMWW, S_DONE} state_e;

  state_e            state;
  pwr_op_e           op;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  cnt;
  logic              errQ;

  logic              accept;
  logic              decOk;
  pwr_op_e           decOp;
  logic [IDX_W-1:0]  decCnt;
  logic [7:0]        half;
  logic [7:0]        third;

  assign accept = doorbell && (cmdType == CMD_TYPE) && (state == S_IDLE);
  assign half   = cmdSize >> 1;
  assign third  = cmdSize / 8'd3;

  always_comb begin
    decOk  = 1'b0;
    decOp  = OP_NONE;
    decCnt = '0;
    case (subCmd)
      4'd0: begin
        decOp  = OP_WR;
        decCnt = third[IDX_W-1:0];
        decOk  = (cmdSize == third * 8'd3) && (third != 8'd0) && (third <= MAX_CNT);
      end
      4'd1: begin
        decOp  = OP_RD;
        decCnt = half[IDX_W-1:0];
        decOk  = !cmdSize[0] && (half != 8'd0) && (half <= MAX_CNT);
      end
      4'd2: begin
        decOp  = OP_RMW;
        decCnt = IDX_W'(1);
        decOk  = (cmdSize == 8'd4);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      op    <= OP_NONE;
      idx   <= '0;
      cnt   <= '0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op  <= decOp;
          cnt <= decCnt;
          idx <= '0;
          if (decOk) begin
            state <= S_ACC;
          end else begin
            state <= S_DONE;
            errQ  <= 1'b1;
          end
        end
        S_ACC: begin
          if (op == OP_RMW) begin
            state <= S_RMWW;
          end else if (idx == cnt - IDX_W'(1)) begin
            state <= S_DONE;
            errQ  <= 1'b0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_RMWW: begin
          state <= S_DONE;
          errQ  <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign regRdEn = (state == S_ACC) && (op != OP_WR);
  assign regWrEn = ((state == S_ACC) && (op == OP_WR)) || (state == S_RMWW);
  assign done    = (state == S_DONE);
  assign err     = errQ;

  always_comb begin
    strobe.latch   = accept;
    strobe.capRead = (state == S_ACC) && (op == OP_RD);
    strobe.capOld  = (state == S_ACC) && (op == OP_RMW);
    strobe.op      = op;
    strobe.idx     = idx;
    strobe.cnt     = cnt;
  end
endmodule

// File: rtl/pwr_reg_dpath.sv
module pwr_reg_dpath
  import pwr_reg_pkg::*;
#(
  parameter int unsigned BUF_BYTES = PWR_BUF_BYTES
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [BUF_BYTES*8-1:0] obBuf,
  input  logic [7:0]             regRdData,
  input  pwr_strobe_t            strobe,
  output logic [15:0]            regAddr,
  output logic [7:0]             regWrData,
  output logic [BUF_BYTES*8-1:0] ibBuf
);
  localparam int unsigned IDX_W = PWR_IDX_W;

  logic [7:0]       obQ [BUF_BYTES];
  logic [7:0]       ibQ [BUF_BYTES];
  logic [7:0]       oldVal;
  logic [IDX_W-1:0] aIdx;
  logic [IDX_W-1:0] loPos;
  logic [IDX_W-1:0] hiPos;
  logic [IDX_W-1:0] dataPos;
  logic [7:0]       newVal;
  logic [7:0]       mask;

  assign aIdx    = (strobe.op == OP_RMW) ? '0 : strobe.idx;
  assign loPos   = {aIdx[IDX_W-2:0], 1'b0};
  assign hiPos   = {aIdx[IDX_W-2:0], 1'b1};
  assign dataPos = {strobe.cnt[IDX_W-2:0], 1'b0} + strobe.idx;
  assign newVal  = obQ[2];
  assign mask    = obQ[3];

  assign regAddr   = {obQ[hiPos], obQ[loPos]};
  assign regWrData = (strobe.op == OP_RMW) ? ((newVal & mask) | (oldVal & ~mask))
                                           : obQ[dataPos];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oldVal <= '0;
      for (int i = 0; i < int'(BUF_BYTES); i++) begin
        obQ[i] <= '0;
        ibQ[i] <= '0;
      end
    end else begin
      if (strobe.latch) begin
        for (int i = 0; i < int'(BUF_BYTES); i++) begin
          obQ[i] <= obBuf[i*8 +: 8];
          ibQ[i] <= '0;
        end
      end
      if (strobe.capRead) ibQ[strobe.idx] <= regRdData;
      if (strobe.capOld)  oldVal <= regRdData;
    end
  end

  for (genvar g = 0; g < int'(BUF_BYTES); g++) begin : g_ib
    assign ibBuf[g*8 +: 8] = ibQ[g];
  end
endmodule

// File: rtl/pwr_reg_engine.sv
module pwr_reg_engine
  import pwr_reg_pkg::*;
#(
  parameter int unsigned MAX_ITEMS = 5,
  parameter logic [7:0]  CMD_TYPE  = 8'hFF,
  parameter int unsigned BUF_BYTES = PWR_BUF_BYTES
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   doorbell,
  input  logic [7:0]             cmdType,
  input  logic [3:0]             subCmd,
  input  logic [7:0]             cmdSize,
  input  logic [BUF_BYTES*8-1:0] obBuf,
  output logic [15:0]            regAddr,
  output logic                   regRdEn,
  output logic                   regWrEn,
  output logic [7:0]             regWrData,
  input  logic [7:0]             regRdData,
  output logic [BUF_BYTES*8-1:0] ibBuf,
  output logic                   done,
  output logic                   err
);
  pwr_strobe_t strobe;

  pwr_reg_ctrl #(.MAX_ITEMS(MAX_ITEMS), .CMD_TYPE(CMD_TYPE)) ctrl_i (
    .clk(clk), .rstN(rstN), .doorbell(doorbell), .cmdType(cmdType),
    .subCmd(subCmd), .cmdSize(cmdSize), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .done(done), .err(err), .strobe(strobe)
  );

  pwr_reg_dpath #(.BUF_BYTES(BUF_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .obBuf(obBuf), .regRdData(regRdData),
    .strobe(strobe), .regAddr(regAddr), .regWrData(regWrData), .ibBuf(ibBuf)
  );
endmodule

// File: rtl/pwr_reg_engine_chk.sv
module pwr_reg_engine_chk #(
  parameter int unsigned MAX_ITEMS = 5,
  parameter logic [7:0]  CMD_TYPE  = 8'hFF
) (
  input logic       clk,
  input logic       rstN,
  input logic       doorbell,
  input logic [7:0] cmdType,
  input logic       regRdEn,
  input logic       regWrEn,
  input logic       done,
  input logic       err
);
  logic       busyChk;
  logic [7:0] accCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyChk <= 1'b0;
      accCnt  <= '0;
    end else begin
      if (done) busyChk <= 1'b0;
      else if (doorbell && cmdType == CMD_TYPE && !busyChk) busyChk <= 1'b1;
      if (done) accCnt <= '0;
      else if (regRdEn || regWrEn) accCnt <= accCnt + 8'd1;
    end
  end

  p_no_dual_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regWrEn));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_moves_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(err) |-> done);

  p_bus_quiet_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !(regRdEn || regWrEn));

  p_foreign_type_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doorbell && cmdType != CMD_TYPE && !busyChk) |=> !(regRdEn || regWrEn || done));

  p_access_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    accCnt <= 8'(MAX_ITEMS));
endmodule

bind pwr_reg_engine pwr_reg_engine_chk #(.MAX_ITEMS(MAX_ITEMS), .CMD_TYPE(CMD_TYPE)) chk_i (
  .clk(clk), .rstN(rstN), .doorbell(doorbell), .cmdType(cmdType),
  .regRdEn(regRdEn), .regWrEn(regWrEn), .done(done), .err(err)
);

// File: tb/pwr_reg_engine_tb_top.sv
module pwr_reg_engine_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         doorbell = 1'b0;
  logic [7:0]   cmdType = '0;
  logic [3:0]   subCmd = '0;
  logic [7:0]   cmdSize = '0;
  logic [127:0] obBuf = '0;
  logic [15:0]  regAddr;
  logic         regRdEn, regWrEn;
  logic [7:0]   regWrData, regRdData;
  logic [127:0] ibBuf;
  logic         done, err;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0]  rf [256];
  logic [15:0] logA [256];
  logic        logW [256];
  logic [7:0]  logD [256];
  int          logN = 0;
  int          base = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_reg_engine dut_i (
    .clk(clk), .rstN(rstN), .doorbell(doorbell), .cmdType(cmdType),
    .subCmd(subCmd), .cmdSize(cmdSize), .obBuf(obBuf), .regAddr(regAddr),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ibBuf(ibBuf), .done(done), .err(err)
  );

  assign regRdData = rf[regAddr[7:0]];

  function automatic logic [7:0] initVal(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) rf[i] <= initVal(i);
    end else begin
      if (regWrEn) rf[regAddr[7:0]] <= regWrData;
      if (regRdEn || regWrEn) begin
        logA[logN[7:0]] <= regAddr;
        logW[logN[7:0]] <= regWrEn;
        logD[logN[7:0]] <= regWrEn ? regWrData : regRdData;
        logN <= logN + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // drive one command, wait for done; lat = negedges until done, -1 if none
  task automatic runCmd(input logic [7:0] t, input logic [3:0] s, input logic [7:0] sz,
                        input logic [127:0] b, output int lat, output logic e);
    @(negedge clk);
    cmdType = t; subCmd = s; cmdSize = sz; obBuf = b; doorbell = 1'b1;
    base = logN;
    @(negedge clk);
    doorbell = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    e = err;
    if (!done) lat = -1;
  endtask

  function automatic logic [127:0] putAddr(logic [127:0] b, int i, logic [15:0] a);
    logic [127:0] r = b;
    r[(2*i)*8 +: 8]   = a[7:0];
    r[(2*i+1)*8 +: 8] = a[15:8];
    return r;
  endfunction

  task automatic t_reset();
    check(!done && !err && !regRdEn && !regWrEn, "R1 control outputs", {done, err, regRdEn, regWrEn}, 0);
    check(ibBuf == '0, "R1 ibBuf", ibBuf, 0);
  endtask

  task automatic t_read(input int n, input string tag);
    logic [127:0] b = '0;
    logic [127:0] expIb = '0;
    logic [15:0]  a;
    int lat; logic e;
    for (int i = 0; i < n; i++) begin
      a = 16'h1100 * 16'(i + 1) + 16'(8'h13 * (i + 3));
      b = putAddr(b, i, a);
      expIb[i*8 +: 8] = rf[a[7:0]];
    end
    runCmd(8'hFF, 4'd1, 8'(2 * n), b, lat, e);
    check(lat == n + 1 && !e, {tag, " R6 latency/err"}, {lat[7:0], 7'd0, e}, {8'(n + 1), 8'd0});
    check(ibBuf == expIb, {tag, " R3 ibBuf"}, ibBuf, expIb);
    check(logN - base == n, {tag, " R2 access count"}, logN - base, n);
    for (int i = 0; i < n; i++) begin
      check(!logW[(base + i) % 256] && logA[(base + i) % 256] == {b[(2*i+1)*8 +: 8], b[(2*i)*8 +: 8]},
            {tag, " R2 address order"}, logA[(base + i) % 256], {b[(2*i+1)*8 +: 8], b[(2*i)*8 +: 8]});
    end
    @(negedge clk);
    check(!done, {tag, " R6 single pulse"}, done, 0);
  endtask

  task automatic t_write(input int n, input string tag);
    logic [127:0] b = '0;
    logic [15:0]  a;
    logic [7:0]   d;
    int lat; logic e;
    for (int i = 0; i < n; i++) begin
      a = 16'h0201 * 16'(i + 1) + 16'h0040;
      b = putAddr(b, i, a);
      b[(2*n + i)*8 +: 8] = 8'hA0 + 8'(i * 7);
    end
    runCmd(8'hFF, 4'd0, 8'(3 * n), b, lat, e);
    check(lat == n + 1 && !e, {tag, " R6 latency/err"}, {lat[7:0], 7'd0, e}, {8'(n + 1), 8'd0});
    check(logN - base == n, {tag, " R4 access count"}, logN - base, n);
    for (int i = 0; i < n; i++) begin
      a = {b[(2*i+1)*8 +: 8], b[(2*i)*8 +: 8]};
      d = b[(2*n + i)*8 +: 8];
      check(logW[(base + i) % 256] && logA[(base + i) % 256] == a && logD[(base + i) % 256] == d,
            {tag, " R4 write item"}, {logA[(base + i) % 256], logD[(base + i) % 256]}, {a, d});
      check(rf[a[7:0]] == d, {tag, " R4 register content"}, rf[a[7:0]], d);
    end
  endtask

  task automatic t_rmw();
    logic [127:0] b = '0;
    logic [7:0] oldV, expV;
    int lat; logic e;
    b = putAddr(b, 0, 16'h0533);
    b[2*8 +: 8] = 8'hF0;
    b[3*8 +: 8] = 8'h3C;
    oldV = rf[8'h33];
    expV = (8'hF0 & 8'h3C) | (oldV & ~8'h3C);
    runCmd(8'hFF, 4'd2, 8'd4, b, lat, e);
    check(lat == 3 && !e, "R5 latency/err", {lat[7:0], 7'd0, e}, {8'd3, 8'd0});
    check(logN - base == 2 && !logW[base % 256] && logW[(base + 1) % 256],
          "R5 read then write", {logW[base % 256], logW[(base + 1) % 256]}, 2'b01);
    check(logA[base % 256] == 16'h0533 && logA[(base + 1) % 256] == 16'h0533,
          "R5 same address", logA[(base + 1) % 256], 16'h0533);
    check(rf[8'h33] == expV, "R5 merged value", rf[8'h33], expV);
    check(ibBuf == '0, "R5 ibBuf untouched", ibBuf, 0);
  endtask

  task automatic t_reject(input logic [3:0] s, input logic [7:0] sz, input string tag);
    logic [127:0] b = '0;
    int lat; logic e;
    for (int i = 0; i < 16; i++) b[i*8 +: 8] = 8'(i + 1);
    runCmd(8'hFF, s, sz, b, lat, e);
    check(lat == 1 && e, {tag, " R7 immediate error"}, {lat[7:0], 7'd0, e}, {8'd1, 8'd1});
    check(logN == base, {tag, " R7 no access"}, logN - base, 0);
    check(ibBuf == '0, {tag, " R7 ibBuf zero"}, ibBuf, 0);
  endtask

  task automatic t_foreign();
    logic sawDone = 1'b0;
    @(negedge clk);
    base = logN;
    cmdType = 8'h10; subCmd = 4'd1; cmdSize = 8'd2; obBuf = 128'h0011; doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (done) sawDone = 1'b1;
      @(negedge clk);
    end
    check(!sawDone, "R8 no done", sawDone, 0);
    check(logN == base, "R8 no access", logN - base, 0);
  endtask

  task automatic t_busy();
    logic [127:0] b = '0;
    logic [7:0] keep = rf[8'h77];
    int lat = 1;
    for (int i = 0; i < 4; i++) b = putAddr(b, i, 16'h0060 + 16'(i));
    @(negedge clk);
    cmdType = 8'hFF; subCmd = 4'd1; cmdSize = 8'd8; obBuf = b; doorbell = 1'b1;
    base = logN;
    @(negedge clk);
    doorbell = 1'b0;
    @(negedge clk);
    lat = 2;
    cmdType = 8'hFF; subCmd = 4'd0; cmdSize = 8'd3; obBuf = 128'h00_0077; doorbell = 1'b1;
    @(negedge clk);
    lat = 3;
    doorbell = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 5 && !err, "R9 running command completes", lat, 5);
    check(logN - base == 4, "R9 no extra access", logN - base, 4);
    check(rf[8'h77] == keep, "R9 second write not done", rf[8'h77], keep);
    for (int k = 0; k < 4; k++) @(negedge clk);
    check(logN - base == 4 && !done, "R9 nothing after", logN - base, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_read(3, "read3");
    t_write(2, "write2");
    t_rmw();
    t_read(5, "read5");
    t_write(5, "write5");
    t_write(1, "write1");
    t_reject(4'd3, 8'd4, "subcmd3");
    t_reject(4'd1, 8'd3, "read odd size");
    t_reject(4'd0, 8'd7, "write size 7");
    t_reject(4'd1, 8'd0, "read zero");
    t_reject(4'd1, 8'd12, "read six items");
    t_reject(4'd0, 8'd18, "write six items");
    t_reject(4'd2, 8'd3, "rmw size 3");
    t_read(1, "read1 after error");
    t_foreign();
    t_busy();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule